// File: doc/BRIEF.md
# Descriptor Queue Manager with Pend Levels

This block keeps a set of hardware FIFO queues, each holding 32-bit descriptor pointers. Software or a hardware producer reaches every queue through its own data register on a small register bus with separate write and read channels. Writing a queue's data register adds the written pointer at the tail of that queue. Reading the same register removes the head entry and returns it. Neither action needs any other register access.

A fixed, contiguous range of queues drives a vector of pend outputs. Each pend output can feed one interrupt controller input or one DMA transmit channel. A pend bit is a level. It rises when its queue goes from empty to holding an entry, and it stays high until a read takes the last entry out. Status registers report each queue's entry count, the empty and full vectors, a sticky overflow flag per queue, and a copy of the pend vector.

Because the write channel and the read channel are independent, a producer and a consumer can work on the same queue in the same cycle without stalling each other.

Top module: `qm_desc_mgr`

## Requirements
- R1: A write with address bits [5:4] = 0 and bits [3:0] = q appends wr_data_i to the tail of queue q.
- R2: A read with address bits [5:4] = 0 and bits [3:0] = q removes the head of queue q. The read data is that pointer, presented on rd_data_o from the clock edge that takes the read. Entries leave each queue in the order they were written.
- R3: A data read of an empty queue returns zero and leaves the queue's count and contents unchanged.
- R4: A push to a queue that already holds 16 entries is discarded, and bit q of the overflow register (region 2, index 2) is set. The flag stays set until a write to that register with bit q = 1 clears it.
- R5: pend_o[k] is high exactly when queue 4+k holds at least one entry, for k = 0..9. Pushes to queues 0..3 and 14..15 never raise any pend bit.
- R6: Once a pend bit is high, it goes low only through a pop of the last entry of its queue. Pops that leave entries behind keep it high.
- R7: A push and a pop to the same queue in the same cycle pop first and then push. On a full queue the push is accepted, the count stays at 16 and no overflow is flagged. On an empty queue the read returns zero and the count becomes 1.
- R8: A read in region 1 at index q returns queue q's entry count, from 0 to 16. Writes to region 1 have no effect.
- R9: Region 2 reads return the following. Index 0 gives the empty vector, index 1 the full vector, and index 2 the overflow flags, each with bit q for queue q. Index 3 gives the pend vector.
- R10: After reset, all queues are empty, the pend vector and overflow flags are zero, and rd_data_o is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | 6 | Write address: region in [5:4], index in [3:0] |
| wr_data_i | input | 32 | Write data: descriptor pointer or clear mask |
| rd_en_i | input | 1 | Read strobe (a data-region read pops) |
| rd_addr_i | input | 6 | Read address: region in [5:4], index in [3:0] |
| rd_data_o | output | 32 | Registered read data, updated on the edge that takes the read |
| pend_o | output | 10 | Non-empty levels of queues 4 to 13 |

## Verification
A push on the write channel and a pop on the read channel can hit the same queue in the same cycle. The bench provokes this on a queue filled to 16 entries and on an empty queue. For the full queue, it expects the count to stay at 16, no overflow flag to be set, and the later drain to return the surviving entries in order. For the empty queue, it expects a zero read and a count of one afterwards. A random phase also issues both channels together across all queues, and a scoreboard model applies the pop before the push and judges every returned word.

// File: rtl/qm_pkg.sv
package qm_pkg;
  localparam int unsigned NUM_Q_DEF     = 16;
  localparam int unsigned Q_DEPTH_DEF   = 16;
  localparam int unsigned DW_DEF        = 32;
  localparam int unsigned PEND_BASE_DEF = 4;
  localparam int unsigned PEND_CNT_DEF  = 10;

  typedef enum logic [1:0] {
    REG_DATA   = 2'd0,
    REG_COUNT  = 2'd1,
    REG_STATUS = 2'd2,
    REG_RSVD   = 2'd3
  } qm_region_e;

  localparam logic [1:0] ST_EMPTY = 2'd0;
  localparam logic [1:0] ST_FULL  = 2'd1;
  localparam logic [1:0] ST_OVF   = 2'd2;
  localparam logic [1:0] ST_PEND  = 2'd3;
endpackage

// File: rtl/qm_fifo.sv
module qm_fifo #(
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned PW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [DW-1:0] din_i,
  output logic [DW-1:0] head_o,
  output logic [CW-1:0] count_o,
  output logic          full_o,
  output logic          empty_o,
  output logic          ovf_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [PW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] count_q;
  logic          do_pop, do_push;

  assign empty_o = (count_q == '0);
  assign full_o  = (count_q == CW'(DEPTH));
  // pop is resolved first, freeing a slot for a same-cycle push
  assign do_pop  = pop_i && !empty_o;
  assign do_push = push_i && (!full_o || do_pop);
  assign ovf_o   = push_i && !do_push;
  assign head_o  = empty_o ? '0 : mem_q[rd_ptr_q];
  assign count_o = count_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (do_push) wr_ptr_q <= wr_ptr_q + 1'b1;
      if (do_pop)  rd_ptr_q <= rd_ptr_q + 1'b1;
      count_q <= count_q + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_ptr_q] <= din_i;
  end

  assert_count_bound_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CW'(DEPTH));
  assert_empty_pop_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && empty_o) |=> (count_q == '0));
  assert_no_overflow_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i && full_o) |=> (count_q == CW'(DEPTH)) && $stable(wr_ptr_q));
  assert_same_cycle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && pop_i && !empty_o) |=> $stable(count_q));
endmodule

// File: rtl/qm_reg_dec.sv
module qm_reg_dec
  import qm_pkg::*;
#(
  parameter int unsigned NUM_Q = 16,
  localparam int unsigned QW   = $clog2(NUM_Q),
  localparam int unsigned AW   = QW + 2
) (
  input  logic             wr_en_i,
  input  logic [AW-1:0]    wr_addr_i,
  input  logic             rd_en_i,
  input  logic [AW-1:0]    rd_addr_i,
  output logic [NUM_Q-1:0] push_o,
  output logic [NUM_Q-1:0] pop_o,
  output logic             ovf_clr_o,
  output qm_region_e       rd_reg_o,
  output logic [QW-1:0]    rd_idx_o
);
  qm_region_e  wr_reg;
  logic [QW-1:0] wr_idx;

  assign wr_reg   = qm_region_e'(wr_addr_i[AW-1 -: 2]);
  assign wr_idx   = wr_addr_i[QW-1:0];
  assign rd_reg_o = qm_region_e'(rd_addr_i[AW-1 -: 2]);
  assign rd_idx_o = rd_addr_i[QW-1:0];

  always_comb begin
    push_o = '0;
    pop_o  = '0;
    if (wr_en_i && wr_reg == REG_DATA) push_o[wr_idx]   = 1'b1;
    if (rd_en_i && rd_reg_o == REG_DATA) pop_o[rd_idx_o] = 1'b1;
  end

  assign ovf_clr_o = wr_en_i && (wr_reg == REG_STATUS) && (wr_idx[1:0] == ST_OVF);
endmodule

// File: rtl/qm_ovf_flags.sv
module qm_ovf_flags #(
  parameter int unsigned NUM_Q = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NUM_Q-1:0] set_i,
  input  logic [NUM_Q-1:0] clr_i,
  output logic [NUM_Q-1:0] flag_o
);
  // set has priority over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_o <= '0;
    else         flag_o <= (flag_o & ~clr_i) | set_i;
  end

  for (genvar i = 0; i < NUM_Q; i++) begin : g_chk
    assert_sticky_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_o[i] && !clr_i[i]) |=> flag_o[i]);
  end
endmodule

// File: rtl/qm_desc_mgr.sv
module qm_desc_mgr
  import qm_pkg::*;
#(
  parameter int unsigned NUM_Q     = NUM_Q_DEF,
  parameter int unsigned Q_DEPTH   = Q_DEPTH_DEF,
  parameter int unsigned DW        = DW_DEF,
  parameter int unsigned PEND_BASE = PEND_BASE_DEF,
  parameter int unsigned PEND_CNT  = PEND_CNT_DEF,
  localparam int unsigned QW       = $clog2(NUM_Q),
  localparam int unsigned AW       = QW + 2,
  localparam int unsigned CW       = $clog2(Q_DEPTH + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [AW-1:0]       wr_addr_i,
  input  logic [DW-1:0]       wr_data_i,
  input  logic                rd_en_i,
  input  logic [AW-1:0]       rd_addr_i,
  output logic [DW-1:0]       rd_data_o,
  output logic [PEND_CNT-1:0] pend_o
);
  logic [NUM_Q-1:0] push_vec, pop_vec, empty_vec, full_vec, ovf_set, ovf_flag, ovf_clr;
  logic [DW-1:0]    head_w  [NUM_Q];
  logic [CW-1:0]    count_w [NUM_Q];
  logic             ovf_clr_en;
  qm_region_e       rd_reg;
  logic [QW-1:0]    rd_idx;
  logic [DW-1:0]    rd_next;

  qm_reg_dec #(.NUM_Q(NUM_Q)) u_dec (
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .rd_en_i   (rd_en_i),
    .rd_addr_i (rd_addr_i),
    .push_o    (push_vec),
    .pop_o     (pop_vec),
    .ovf_clr_o (ovf_clr_en),
    .rd_reg_o  (rd_reg),
    .rd_idx_o  (rd_idx)
  );

  for (genvar q = 0; q < NUM_Q; q++) begin : g_q
    qm_fifo #(.DW(DW), .DEPTH(Q_DEPTH)) u_fifo (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .push_i  (push_vec[q]),
      .pop_i   (pop_vec[q]),
      .din_i   (wr_data_i),
      .head_o  (head_w[q]),
      .count_o (count_w[q]),
      .full_o  (full_vec[q]),
      .empty_o (empty_vec[q]),
      .ovf_o   (ovf_set[q])
    );
  end

  assign ovf_clr = ovf_clr_en ? wr_data_i[NUM_Q-1:0] : '0;

  qm_ovf_flags #(.NUM_Q(NUM_Q)) u_ovf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (ovf_set),
    .clr_i  (ovf_clr),
    .flag_o (ovf_flag)
  );

  for (genvar k = 0; k < PEND_CNT; k++) begin : g_pend
    assign pend_o[k] = !empty_vec[PEND_BASE + k];

    assert_pend_rise_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(pend_o[k]) |-> $past(push_vec[PEND_BASE + k]));
    assert_pend_fall_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(pend_o[k]) |-> $past(pop_vec[PEND_BASE + k]) && !$past(push_vec[PEND_BASE + k]));
  end

  always_comb begin
    rd_next = '0;
    unique case (rd_reg)
      REG_DATA:   rd_next = head_w[rd_idx];
      REG_COUNT:  rd_next = DW'(count_w[rd_idx]);
      REG_STATUS: begin
        unique case (rd_idx[1:0])
          ST_EMPTY: rd_next = DW'(empty_vec);
          ST_FULL:  rd_next = DW'(full_vec);
          ST_OVF:   rd_next = DW'(ovf_flag);
          ST_PEND:  rd_next = DW'(pend_o);
        endcase
      end
      REG_RSVD:   rd_next = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rd_data_o <= '0;
    else if (rd_en_i) rd_data_o <= rd_next;
  end

  assert_empty_read_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && rd_reg == REG_DATA && empty_vec[rd_idx]) |=> (rd_data_o == '0));
endmodule

// File: tb/qm_desc_mgr_bench.sv
module qm_desc_mgr_bench;
  localparam int NQ = 16;
  localparam int DEP = 16;
  localparam int PB = 4;
  localparam int PC = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [5:0]  wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [PC-1:0] pend;

  int n_vec = 0, n_err = 0;
  logic [31:0] mq [NQ][$];
  logic [NQ-1:0] m_ovf = '0;
  logic [31:0] exp_d [$];
  string       exp_t [$];

  always #5 clk = ~clk;

  qm_desc_mgr u_qm_desc_mgr (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_en_i(rd_en), .rd_addr_i(rd_addr),
    .rd_data_o(rd_data), .pend_o(pend));

  function automatic logic [5:0] ad(input int rg, input int idx);
    return {rg[1:0], idx[3:0]};
  endfunction

  function automatic logic [PC-1:0] m_pend();
    logic [PC-1:0] p;
    for (int k = 0; k < PC; k++) p[k] = (mq[PB+k].size() != 0);
    return p;
  endfunction

  function automatic logic [31:0] m_read(input logic [5:0] a);
    int q = int'(a[3:0]);
    logic [31:0] v = '0;
    case (a[5:4])
      2'd0: v = (mq[q].size() != 0) ? mq[q][0] : 32'h0;
      2'd1: v = 32'(mq[q].size());
      2'd2: case (a[1:0])
        2'd0: for (int i = 0; i < NQ; i++) v[i] = (mq[i].size() == 0);
        2'd1: for (int i = 0; i < NQ; i++) v[i] = (mq[i].size() == DEP);
        2'd2: v = 32'(m_ovf);
        default: v = 32'(m_pend());
      endcase
      default: v = '0;
    endcase
    return v;
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  // driver: one bus cycle, scoreboard entry for a read, model pops before pushes
  task automatic op(input bit dw, input logic [5:0] wa, input logic [31:0] wd,
                    input bit dr, input logic [5:0] ra, input string tag);
    if (dr) begin
      exp_d.push_back(m_read(ra));
      exp_t.push_back(tag);
      if (ra[5:4] == 2'd0 && mq[ra[3:0]].size() != 0) void'(mq[ra[3:0]].pop_front());
    end
    if (dw) begin
      if (wa[5:4] == 2'd0) begin
        if (mq[wa[3:0]].size() < DEP) mq[wa[3:0]].push_back(wd);
        else m_ovf[wa[3:0]] = 1'b1;
      end else if (wa[5:4] == 2'd2 && wa[1:0] == 2'd2) begin
        m_ovf = m_ovf & ~wd[NQ-1:0];
      end
    end
    wr_en = dw; wr_addr = wa; wr_data = wd;
    rd_en = dr; rd_addr = ra;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    check({tag, " pend"}, 32'(pend), 32'(m_pend()));
  endtask

  task automatic wr(input int q, input logic [31:0] d, input string tag);
    op(1'b1, ad(0, q), d, 1'b0, '0, tag);
  endtask
  task automatic rd(input int rg, input int idx, input string tag);
    op(1'b0, '0, '0, 1'b1, ad(rg, idx), tag);
  endtask

  // monitor: compares read data one edge after the strobe
  always begin
    bit fire;
    @(posedge clk);
    fire = rd_en && rst_n;
    @(negedge clk);
    if (fire) begin
      if (exp_d.size() == 0) begin
        n_vec++; n_err++;
        $display("FAIL scoreboard underrun got %h expected none", rd_data);
      end else check(exp_t.pop_front(), rd_data, exp_d.pop_front());
    end
  end

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_vec++; n_err++;
    $display("FAIL watchdog got hang expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10 pend", 32'(pend), 32'h0);
    check("R10 rd_data", rd_data, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    rd(2, 0, "R10 empty vec");
    rd(2, 2, "R10 ovf vec");

    // R1 R2 basic order
    wr(0, 32'hA000_0001, "R1");
    wr(0, 32'hA000_0002, "R1");
    wr(0, 32'hA000_0003, "R1");
    rd(1, 0, "R8 count 3");
    rd(0, 0, "R2"); rd(0, 0, "R2"); rd(0, 0, "R2");
    rd(0, 0, "R3 empty read");
    rd(1, 0, "R3 count stays 0");
    op(1'b1, ad(1, 0), 32'h5, 1'b0, '0, "R8 count write");
    rd(1, 0, "R8 count unchanged");

    // R5 R6 pend behaviour
    wr(3, 32'h3, "R5 q3 no pend");
    wr(14, 32'hE, "R5 q14 no pend");
    wr(4, 32'h40, "R5 q4 rise");
    wr(4, 32'h41, "R5");
    rd(0, 4, "R6 partial pop");
    rd(2, 3, "R9 pend vec");
    rd(0, 4, "R6 last pop");
    wr(13, 32'hD0, "R5 q13 bit9");
    rd(0, 13, "R6");
    rd(0, 3, "R2"); rd(0, 14, "R2");

    // R4 overflow
    for (int i = 0; i < DEP; i++) wr(5, 32'h5000 + i, "R1 fill");
    rd(1, 5, "R8 count 16");
    rd(2, 1, "R9 full vec");
    wr(5, 32'hDEAD_0000, "R4 drop");
    rd(2, 2, "R4 ovf set");
    rd(1, 5, "R4 count held");
    op(1'b1, ad(2, 2), 32'h0, 1'b0, '0, "R4 clear zero");
    rd(2, 2, "R4 still set");
    op(1'b1, ad(2, 2), 32'h20, 1'b0, '0, "R4 w1c");
    rd(2, 2, "R4 cleared");

    // R7 same-cycle push/pop
    op(1'b1, ad(0, 5), 32'h5555_0000, 1'b1, ad(0, 5), "R7 full both");
    rd(2, 2, "R7 no ovf");
    rd(1, 5, "R7 count 16");
    for (int i = 0; i < DEP; i++) rd(0, 5, "R7 drain order");
    op(1'b1, ad(0, 6), 32'h6666_0000, 1'b1, ad(0, 6), "R7 empty both");
    rd(1, 6, "R7 count 1");
    rd(0, 6, "R7 item");

    // random mix
    for (int n = 0; n < 600; n++) begin
      int q = $urandom_range(NQ - 1);
      int r = $urandom_range(NQ - 1);
      int sel = $urandom_range(9);
      bit dw = (sel < 5) || (sel == 9);
      bit dr = (sel >= 4);
      logic [5:0] wa = (sel == 9 && n % 7 == 0) ? ad(2, 2) : ad(0, q);
      logic [5:0] ra = (sel == 8) ? ad($urandom_range(2), r) : ((sel == 7) ? ad(0, q) : ad(0, r));
      op(dw, wa, $urandom, dr, ra, (dw && dr && wa == ra) ? "R7 rand" : "R2 rand");
    end
    for (int i = 0; i < 4; i++) rd(2, i, "R9 final");
    for (int q = 0; q < NQ; q++) rd(1, q, "R8 final");

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule